// File: doc/BRIEF.md
# Memory-Mapped GPIO Controller with Edge Interrupts

This block controls 32 general-purpose pins through a plain 32-bit register bus. The bus has an address, a write strobe with write data, and a read strobe with read data. Software sets three things for each line: whether it drives, whether it drives push-pull or open-drain, and the level it drives. Software reads back driven lines from the output latch. It reads other lines as synchronized pin levels, which pass only when the line's input buffer is enabled.

Every line has an edge detector. A sense bit chooses falling edges only or both edges. Detected edges set bits in a sticky event register, and software clears those bits by writing ones. One interrupt output is high while any event bit is also set in the mask register.

At chip level the controller sits between the register interconnect and the pad ring. Each line has its own output, output-enable and input bit on the pad side.

Top module: `mmio_gpio`

## Requirements
- R1: Every register uses the same bit order: line n sits at bit 31−n, so line 0 is bit 31. Word offsets are 0x00 direction, 0x04 open-drain, 0x08 data, 0x0C event, 0x10 mask, 0x14 sense and 0x18 input-buffer enable. The value addressed while `bus_re` is high is on `bus_rdata` after the next rising clock edge, and it holds until the next read. Reads of any other address return 0, and writes to any other address change nothing.
- R2: A direction bit of 1 makes the line an output, which drives `pad_out` with the latch value. A direction bit of 0 makes the line an input: both `pad_out` and `pad_oe` stay 0.
- R3: An output line whose open-drain bit is 1 raises `pad_oe` only while its latch is 0, and it drives 0 then. When the latch is 1 the line releases the pad. An output line whose open-drain bit is 0 always has `pad_oe` set.
- R4: A read of the data register returns the latch bit for output lines. For input lines it returns the synchronized pin value ANDed with the input-buffer-enable bit.
- R5: A write to the data register loads all 32 latch bits, whatever the direction of each line.
- R6: Pins pass through two synchronizing flops. A pin change applied before clock edge k shows in a data read whose strobe is sampled at edge k+2, but not at edges k or k+1.
- R7: When a line's sense bit is 0, both rising and falling synchronized edges set its event bit. When the sense bit is 1, only falling edges set it.
- R8: A line whose input-buffer-enable bit is 0 sets no event. Switching that bit on while the pin is high does not create an event.
- R9: Writing to the event register clears each bit written as 1. Bits written as 0 keep their value.
- R10: If a new edge and a clearing write reach the same event bit in the same cycle, the bit ends up set.
- R11: `irq` is high exactly when some bit is set in both the event register and the mask register (mask 1 = enabled).
- R12: Reset clears every register. All lines are then inputs with no event pending, and `irq`, `pad_oe` and `bus_rdata` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte address of the register |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| pad_in | input | 32 | Pin levels, indexed by line |
| pad_out | output | 32 | Driven level, indexed by line |
| pad_oe | output | 32 | Drive enable, indexed by line |
| irq | output | 1 | Combined interrupt |

## Verification
Most wrong internal state shows at a port within one cycle. A bad direction, open-drain or latch bit changes `pad_oe` or `pad_out` at the next edge, and a bad event or mask bit changes `irq` at once. Synchronizer and previous-sample state are harder to see: a fault there shows only through a data read or a new event two or three cycles after a pin change. The bench therefore reads back after pin changes and follows each edge through to `irq`. A per-clock model is compared on every port, so a divergence is reported in the cycle it appears.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    // Word index of each register (byte offset / 4); the order is fixed by the bus map.
    typedef enum logic [2:0] {
        SEL_DIR  = 3'd0,
        SEL_OD   = 3'd1,
        SEL_DAT  = 3'd2,
        SEL_EVT  = 3'd3,
        SEL_MSK  = 3'd4,
        SEL_SNS  = 3'd5,
        SEL_IBE  = 3'd6,
        SEL_NONE = 3'd7
    } reg_sel_e;

    localparam int unsigned REG_COUNT = 7;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int unsigned NL = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NL-1:0] d,
    output logic [NL-1:0] q
);
    typedef struct packed {
        logic [NL-1:0] s1;
        logic [NL-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d.s1 = d;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q = st_q.s2;
endmodule

// File: rtl/gpio_evt.sv
module gpio_evt #(
    parameter int unsigned NL = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NL-1:0] smp,    // synchronized pins, register bit order
    input  logic [NL-1:0] ibe,
    input  logic [NL-1:0] sns,    // 1: falling only, 0: both edges
    input  logic [NL-1:0] clr,    // write-one-to-clear bits this cycle
    output logic [NL-1:0] evt,
    output logic [NL-1:0] prv
);
    typedef struct packed {
        logic [NL-1:0] prev;
        logic [NL-1:0] evt;
    } evt_t;

    evt_t st_d, st_q;
    logic [NL-1:0] hit;

    always_comb begin
        // Edges come from the raw synchronized samples, so toggling ibe alone never creates one.
        hit       = ibe & ((sns & st_q.prev & ~smp) | (~sns & (st_q.prev ^ smp)));
        st_d.prev = smp;
        st_d.evt  = (st_q.evt & ~clr) | hit;   // a new edge beats a clear
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign evt = st_q.evt;
    assign prv = st_q.prev;
endmodule

// File: rtl/gpio_padmap.sv
module gpio_padmap #(
    parameter int unsigned NL = 32
) (
    input  logic [NL-1:0] out_reg,
    input  logic [NL-1:0] oe_reg,
    input  logic [NL-1:0] pad_in,
    output logic [NL-1:0] pad_out,
    output logic [NL-1:0] pad_oe,
    output logic [NL-1:0] pin_reg
);
    // Pads are indexed by line; registers keep line n at bit NL-1-n.
    for (genvar n = 0; n < NL; n++) begin : g_line
        assign pad_out[n]        = out_reg[NL-1-n];
        assign pad_oe[n]         = oe_reg[NL-1-n];
        assign pin_reg[NL-1-n]   = pad_in[n];
    end
endmodule

// File: rtl/mmio_gpio.sv
module mmio_gpio
    import gpio_pkg::*;
#(
    parameter int unsigned NL = 32,
    parameter int unsigned AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_we,
    input  logic [NL-1:0] bus_wdata,
    input  logic          bus_re,
    output logic [NL-1:0] bus_rdata,
    input  logic [NL-1:0] pad_in,
    output logic [NL-1:0] pad_out,
    output logic [NL-1:0] pad_oe,
    output logic          irq
);
    localparam int unsigned WAW = AW - 2;

    typedef struct packed {
        logic [NL-1:0] dir;
        logic [NL-1:0] od;
        logic [NL-1:0] dat;
        logic [NL-1:0] msk;
        logic [NL-1:0] sns;
        logic [NL-1:0] ibe;
        logic [NL-1:0] rdata;
    } regs_t;

    regs_t         r_d, r_q;
    reg_sel_e      sel;
    logic [NL-1:0] pin_reg, smp, evt, prv, clr, dat_view, out_reg, oe_reg;

    // Plain views of register state for the bound checker.
    logic [NL-1:0] dir_v, od_v, dat_v, msk_v, sns_v, ibe_v;
    assign dir_v = r_q.dir;
    assign od_v  = r_q.od;
    assign dat_v = r_q.dat;
    assign msk_v = r_q.msk;
    assign sns_v = r_q.sns;
    assign ibe_v = r_q.ibe;

    gpio_padmap #(.NL(NL)) u_padmap (
        .out_reg (out_reg),
        .oe_reg  (oe_reg),
        .pad_in  (pad_in),
        .pad_out (pad_out),
        .pad_oe  (pad_oe),
        .pin_reg (pin_reg)
    );

    gpio_sync #(.NL(NL)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_reg),
        .q     (smp)
    );

    gpio_evt #(.NL(NL)) u_evt (
        .clk   (clk),
        .rst_n (rst_n),
        .smp   (smp),
        .ibe   (r_q.ibe),
        .sns   (r_q.sns),
        .clr   (clr),
        .evt   (evt),
        .prv   (prv)
    );

    always_comb begin
        sel = SEL_NONE;
        if (bus_addr[1:0] == 2'b00 && bus_addr[AW-1:2] < WAW'(REG_COUNT))
            sel = reg_sel_e'(bus_addr[4:2]);

        dat_view = (r_q.dat & r_q.dir) | (smp & r_q.ibe & ~r_q.dir);
        clr      = (bus_we && sel == SEL_EVT) ? bus_wdata : '0;
        out_reg  = r_q.dat & r_q.dir;
        oe_reg   = r_q.dir & (~r_q.od | ~r_q.dat);

        r_d = r_q;
        if (bus_re) begin
            unique case (sel)
                SEL_DIR: r_d.rdata = r_q.dir;
                SEL_OD:  r_d.rdata = r_q.od;
                SEL_DAT: r_d.rdata = dat_view;
                SEL_EVT: r_d.rdata = evt;
                SEL_MSK: r_d.rdata = r_q.msk;
                SEL_SNS: r_d.rdata = r_q.sns;
                SEL_IBE: r_d.rdata = r_q.ibe;
                default: r_d.rdata = '0;
            endcase
        end
        if (bus_we) begin
            unique case (sel)
                SEL_DIR: r_d.dir = bus_wdata;
                SEL_OD:  r_d.od  = bus_wdata;
                SEL_DAT: r_d.dat = bus_wdata;
                SEL_MSK: r_d.msk = bus_wdata;
                SEL_SNS: r_d.sns = bus_wdata;
                SEL_IBE: r_d.ibe = bus_wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign bus_rdata = r_q.rdata;
    assign irq       = |(evt & r_q.msk);
endmodule

// File: rtl/gpio_chk.sv
module gpio_chk #(
    parameter int unsigned NL = 32,
    parameter int unsigned AW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] bus_addr,
    input logic          bus_we,
    input logic [NL-1:0] bus_wdata,
    input logic [NL-1:0] pad_out,
    input logic [NL-1:0] pad_oe,
    input logic          irq,
    input logic [NL-1:0] dir,
    input logic [NL-1:0] od,
    input logic [NL-1:0] dat,
    input logic [NL-1:0] ibe,
    input logic [NL-1:0] sns,
    input logic [NL-1:0] smp,
    input logic [NL-1:0] prv,
    input logic [NL-1:0] evt
);
    function automatic logic [NL-1:0] flip(input logic [NL-1:0] v);
        logic [NL-1:0] f;
        for (int i = 0; i < NL; i++) f[i] = v[NL-1-i];
        return f;
    endfunction

    a_r12_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pad_oe == '0 && !irq));

    a_r2_oe_needs_output: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & ~flip(dir)) == '0);

    a_r3_od_drives_low_only: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & flip(od) & pad_out) == '0);

    a_r5_data_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == AW'(8)) |=> dat == $past(bus_wdata));

    a_r8_no_event_when_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (evt & ~$past(evt) & ~$past(ibe)) == '0);

    a_r7_falling_only: assert property (@(posedge clk) disable iff (!rst_n)
        (evt & ~$past(evt) & $past(sns) & ~($past(prv) & ~$past(smp))) == '0);
endmodule

bind mmio_gpio gpio_chk #(.NL(NL), .AW(AW)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe),
    .irq       (irq),
    .dir       (dir_v),
    .od        (od_v),
    .dat       (dat_v),
    .ibe       (ibe_v),
    .sns       (sns_v),
    .smp       (smp),
    .prv       (prv),
    .evt       (evt)
);

// File: tb/test_mmio_gpio.sv
module test_mmio_gpio;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_re = 1'b0;
    logic [31:0] bus_rdata;
    logic [31:0] pad_in = '0;
    logic [31:0] pad_out, pad_oe;
    logic        irq;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #4 clk = ~clk;   // 125 MHz

    mmio_gpio i_mmio_gpio (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_re(bus_re), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
    );

    // ---------------- reference model, indexed by line ----------------
    bit m_dir[32], m_od[32], m_dat[32], m_msk[32], m_sns[32], m_ibe[32];
    bit m_s1[32], m_s2[32], m_prev[32], m_evt[32];
    logic [31:0] m_rd = '0;

    function automatic logic [31:0] pk(input bit a[32]);
        logic [31:0] v;
        for (int n = 0; n < 32; n++) v[31-n] = a[n];
        return v;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int n = 0; n < 32; n++) begin
                m_dir[n] = 0; m_od[n] = 0; m_dat[n] = 0; m_msk[n] = 0; m_sns[n] = 0;
                m_ibe[n] = 0; m_s1[n] = 0; m_s2[n] = 0; m_prev[n] = 0; m_evt[n] = 0;
            end
            m_rd = '0;
        end else begin
            if (bus_re) begin
                case (bus_addr)
                    8'h00: m_rd = pk(m_dir);
                    8'h04: m_rd = pk(m_od);
                    8'h08: for (int n = 0; n < 32; n++)
                               m_rd[31-n] = m_dir[n] ? m_dat[n] : (m_s2[n] & m_ibe[n]);
                    8'h0C: m_rd = pk(m_evt);
                    8'h10: m_rd = pk(m_msk);
                    8'h14: m_rd = pk(m_sns);
                    8'h18: m_rd = pk(m_ibe);
                    default: m_rd = '0;
                endcase
            end
            for (int n = 0; n < 32; n++) begin
                bit hit, clr;
                hit = m_ibe[n] && (m_sns[n] ? (m_prev[n] && !m_s2[n]) : (m_prev[n] != m_s2[n]));
                clr = bus_we && bus_addr == 8'h0C && bus_wdata[31-n];
                m_evt[n]  = (m_evt[n] && !clr) || hit;
                m_prev[n] = m_s2[n];
                m_s2[n]   = m_s1[n];
                m_s1[n]   = pad_in[n];
                if (bus_we) begin
                    case (bus_addr)
                        8'h00: m_dir[n] = bus_wdata[31-n];
                        8'h04: m_od[n]  = bus_wdata[31-n];
                        8'h08: m_dat[n] = bus_wdata[31-n];
                        8'h10: m_msk[n] = bus_wdata[31-n];
                        8'h14: m_sns[n] = bus_wdata[31-n];
                        8'h18: m_ibe[n] = bus_wdata[31-n];
                        default: ;
                    endcase
                end
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic [31:0] eoe, eout, emi;
            for (int n = 0; n < 32; n++) begin
                eoe[n]  = m_dir[n] && (!m_od[n] || !m_dat[n]);
                eout[n] = m_dir[n] && m_dat[n];
                emi[n]  = m_evt[n] && m_msk[n];
            end
            chk(pad_oe == eoe, "R2 R3 pad_oe", pad_oe, eoe);
            chk(pad_out == eout, "R2 R3 pad_out", pad_out, eout);
            chk(irq == (|emi), "R11 irq", {31'd0, irq}, {31'd0, |emi});
            chk(bus_rdata == m_rd, "R1 R4 R6 rdata", bus_rdata, m_rd);
        end
    end

    // ---------------- bus tasks ----------------
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_re = 1'b1;
        @(negedge clk);
        bus_re = 1'b0;
        d = bus_rdata;
    endtask

    task automatic idle(input int c);
        repeat (c) @(negedge clk);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog act=%h exp=%h", 32'd0, 32'd1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // ---------------- directed sequence ----------------
    initial begin
        logic [31:0] v;
        logic [31:0] a0, a1, a2;
        idle(3);
        rst_n = 1'b1;

        // R12: everything clear after reset
        for (int i = 0; i < 7; i++) begin
            rd(8'(i * 4), v);
            chk(v == 32'h0, "R12 reset register", v, 32'h0);
        end
        chk(pad_oe == 32'h0, "R12 pad_oe", pad_oe, 32'h0);
        chk({31'd0, irq} == 32'h0, "R12 irq", {31'd0, irq}, 32'h0);

        // R1 R2: line 0 is bit 31, line 31 is bit 0
        wr(8'h00, 32'h8000_0001);
        wr(8'h08, 32'hC000_0001);
        idle(1);
        chk(pad_oe == 32'h8000_0001, "R1 R2 pad_oe lines 0 and 31", pad_oe, 32'h8000_0001);
        chk(pad_out == 32'h8000_0001, "R1 R2 pad_out", pad_out, 32'h8000_0001);
        rd(8'h08, v);
        chk(v == 32'h8000_0001, "R4 output lines read latch", v, 32'h8000_0001);

        // R5: latch written while line 1 was an input
        wr(8'h00, 32'h4000_0000);
        rd(8'h08, v);
        chk(v == 32'h4000_0000, "R5 latch kept for input line", v, 32'h4000_0000);
        chk(pad_out == 32'h0000_0002, "R5 pad_out line 1", pad_out, 32'h0000_0002);

        // R3: open drain
        wr(8'h04, 32'h4000_0000);
        idle(1);
        chk(pad_oe == 32'h0, "R3 released when latch 1", pad_oe, 32'h0);
        wr(8'h08, 32'h0);
        idle(1);
        chk(pad_oe == 32'h0000_0002, "R3 drives when latch 0", pad_oe, 32'h0000_0002);
        chk(pad_out == 32'h0, "R3 drives low", pad_out, 32'h0);

        // R4 R8 R7: inputs, lines 16..31 buffered
        wr(8'h04, 32'h0);
        wr(8'h00, 32'h0);
        wr(8'h18, 32'h0000_FFFF);
        @(negedge clk); pad_in = 32'h0001_0001;
        idle(4);
        rd(8'h08, v);
        chk(v == 32'h0000_8000, "R4 R8 gated input read", v, 32'h0000_8000);
        rd(8'h0C, v);
        chk(v == 32'h0000_8000, "R7 R8 rising edge event", v, 32'h0000_8000);

        // R9: write-one-to-clear
        wr(8'h0C, 32'h0000_0001);
        rd(8'h0C, v);
        chk(v == 32'h0000_8000, "R9 zero bits keep event", v, 32'h0000_8000);
        wr(8'h0C, 32'h0000_8000);
        rd(8'h0C, v);
        chk(v == 32'h0, "R9 one clears event", v, 32'h0);

        // R6: synchronizer latency on line 17 (bit 14)
        @(negedge clk); pad_in = 32'h0003_0001;
        bus_addr = 8'h08; bus_re = 1'b1;
        @(negedge clk); a0 = bus_rdata;
        @(negedge clk); a1 = bus_rdata;
        @(negedge clk); a2 = bus_rdata;
        bus_re = 1'b0;
        chk(a0[14] == 1'b0, "R6 edge k old", a0, 32'h0000_8000);
        chk(a1[14] == 1'b0, "R6 edge k+1 old", a1, 32'h0000_8000);
        chk(a2[14] == 1'b1, "R6 edge k+2 new", a2, 32'h0000_C000);

        // R11: masked interrupt on line 17
        wr(8'h10, 32'h0000_4000);
        idle(1);
        chk({31'd0, irq} == 32'h1, "R11 irq with mask", {31'd0, irq}, 32'h1);
        wr(8'h0C, 32'h0000_C000);
        idle(1);
        chk({31'd0, irq} == 32'h0, "R11 irq cleared", {31'd0, irq}, 32'h0);

        // R7: falling-only sense on line 17
        wr(8'h14, 32'h0000_4000);
        @(negedge clk); pad_in = 32'h0001_0001;
        idle(4);
        rd(8'h0C, v);
        chk(v == 32'h0000_4000, "R7 falling edge sets", v, 32'h0000_4000);
        wr(8'h0C, 32'h0000_4000);
        @(negedge clk); pad_in = 32'h0003_0001;
        idle(4);
        rd(8'h0C, v);
        chk(v == 32'h0, "R7 rising edge ignored", v, 32'h0);

        // R8: enabling the buffer on a high pin (line 0) makes no event
        wr(8'h18, 32'h8000_FFFF);
        idle(3);
        rd(8'h0C, v);
        chk(v == 32'h0, "R8 no event on enable", v, 32'h0);
        rd(8'h08, v);
        chk(v == 32'h8000_C000, "R8 enabled input reads", v, 32'h8000_C000);

        // R10: edge and clear on line 17 in the same cycle
        wr(8'h14, 32'h0);
        @(negedge clk); pad_in = 32'h0001_0001;
        idle(4);
        @(negedge clk); pad_in = 32'h0003_0001;   // before edge k
        @(negedge clk);                           // after edge k
        bus_addr = 8'h0C; bus_wdata = 32'h0000_4000; bus_we = 1'b1;
        @(negedge clk);                           // write sampled at edge k+1? no: shift once more
        bus_we = 1'b0;
        idle(2);
        // the write above met the edge at k+1; repeat timed for k+2
        wr(8'h0C, 32'h0000_4000);
        @(negedge clk); pad_in = 32'h0001_0001;   // before edge k
        @(negedge clk);                           // edge k passed
        @(negedge clk);                           // edge k+1 passed
        bus_addr = 8'h0C; bus_wdata = 32'h0000_4000; bus_we = 1'b1;
        @(negedge clk);                           // edge k+2: clear meets edge
        bus_we = 1'b0;
        rd(8'h0C, v);
        chk(v == 32'h0000_4000, "R10 edge wins over clear", v, 32'h0000_4000);

        // R1: unmapped address
        wr(8'h1C, 32'hFFFF_FFFF);
        rd(8'h1C, v);
        chk(v == 32'h0, "R1 unmapped reads zero", v, 32'h0);
        rd(8'h00, v);
        chk(v == 32'h0, "R1 unmapped write ignored", v, 32'h0);

        idle(2);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule